// File: doc/BRIEF.md
# Bit-Serial CRC16 Generator and Checker

This block computes a 16-bit cyclic redundancy check one bit per cycle over the data field of a serial packet. A single shift register serves both the outgoing and the incoming path. A direction select picks which serial stream feeds the register. A start-of-packet pulse loads the register with all ones. After that, every cycle that carries a valid bit advances the register by one step of the polynomial x^16 + x^15 + x^2 + 1.

On the outgoing path, the surrounding logic raises the shift-out request once the final data bit has been fed. For the next 16 valid cycles the register then moves left without feedback. The serial check output presents the inverted top bit, so the ones-complement of the CRC leaves the block most significant bit first.

On the incoming path, the data bits and the 16 received check bits are all fed through the same register. An end-of-data strobe then compares the register with the fixed residual 0x800D. The result is held on a good flag or a bad flag until the next start of packet. Byte assembly and bit unstuffing are done outside this block.

Top module: `crc16_serial_unit`

## Requirements
- R1: When `sop` is high, or when `rst` is high, the register is loaded with 0xFFFF on that edge. This takes priority over any bit, shift or feed input in the same cycle.
- R2: In a feed cycle (`bit_vld`=1, `crc_shift`=0, `sop`=0), let fb = input bit XOR register bit 15. The register becomes (register << 1) XOR (fb ? 0x8005 : 0), truncated to 16 bits.
- R3: With `dir_tx`=1 the feed bit is `tx_bit` and `rx_bit` has no effect. With `dir_tx`=0 the feed bit is `rx_bit` and `tx_bit` has no effect.
- R4: In a cycle with `bit_vld`=0 (and `sop`=0, `rst`=0), the register keeps its value. This holds whatever `crc_shift`, `tx_bit` or `rx_bit` show.
- R5: `crc_out` always equals the inverse of register bit 15. Over 16 consecutive shift cycles it therefore emits the ones-complement of the CRC, most significant bit first.
- R6: In a shift cycle (`bit_vld`=1, `crc_shift`=1), the register moves left by one with a 0 entering bit 0 and no polynomial feedback.
- R7: One cycle after `eod` is high, exactly one flag is set. `good`=1 if the register equalled 0x800D in the `eod` cycle; otherwise `bad`=1.
- R8: After reset, or one cycle after `sop`, both flags are 0. Once set, the flags hold their value until the next `sop` or reset.
- R9: A receive pass over a packet's data followed by the 16 bits sent on `crc_out` yields `good`. The same pass with any single bit inverted yields `bad`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sop | input | 1 | Start of packet; seeds the register and clears the flags |
| bit_vld | input | 1 | The current cycle carries one bit time |
| dir_tx | input | 1 | 1 = transmit stream feeds the register, 0 = receive stream |
| tx_bit | input | 1 | Serial transmit data bit |
| rx_bit | input | 1 | Serial receive data bit |
| crc_shift | input | 1 | Shift the check value out instead of feeding data |
| eod | input | 1 | End of data; compare the register with the residual |
| crc_out | output | 1 | Serial check bit (inverted register MSB) |
| good | output | 1 | Residual matched at the last end-of-data strobe |
| bad | output | 1 | Residual did not match at the last end-of-data strobe |

## Verification
Only bit 15 of the register is visible cycle by cycle, through `crc_out`. An error in the low bits therefore stays hidden until it has moved up. That can take up to 15 feed or shift cycles, or it shows at once as a wrong `good`/`bad` pair one cycle after `eod`, where all 16 bits are compared. The bench keeps its own integer model of the register and checks `crc_out` and both flags on every clock. It also closes each transmit pass by replaying the captured check bits through the receive side, so a wrong polynomial, seed or bit order turns a sound packet into `bad`.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

    // Operation applied to the shared register in one cycle
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_FEED  = 2'd1,
        OP_SHIFT = 2'd2,
        OP_SEED  = 2'd3
    } crc_op_e;

    // Latched outcome of the residual comparison
    typedef struct packed {
        logic valid;
        logic match;
    } verdict_t;

    // Priority: packet start, then shift-out, then data feed
    function automatic crc_op_e decode_op(input logic sop,
                                          input logic bit_vld,
                                          input logic crc_shift);
        crc_op_e op;
        if (sop)
            op = OP_SEED;
        else if (bit_vld && crc_shift)
            op = OP_SHIFT;
        else if (bit_vld)
            op = OP_FEED;
        else
            op = OP_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/crc16_in_mux.sv
module crc16_in_mux (
    input  logic dir_tx,
    input  logic tx_bit,
    input  logic rx_bit,
    output logic sel_bit
);
    // Direction picks which serial stream reaches the register
    always_comb sel_bit = dir_tx ? tx_bit : rx_bit;
endmodule

// File: rtl/crc16_lfsr.sv
module crc16_lfsr
    import crc16_pkg::*;
#(
    parameter int          W    = 16,
    parameter logic [W-1:0] POLY = 16'h8005,
    parameter logic [W-1:0] SEED = 16'hFFFF
) (
    input  logic         clk,
    input  logic         rst,
    input  crc_op_e      op,
    input  logic         din,
    output logic [W-1:0] state
);
    localparam int MSB = W - 1;

    logic         fb;
    logic [W-1:0] nxt_feed;
    logic [W-1:0] nxt_shift;

    assign fb = din ^ state[MSB];

    // One Galois step: each tap bit takes the feedback XOR
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_tap
            if (i == 0) begin : g_lsb
                assign nxt_feed[i]  = fb & POLY[i];
                assign nxt_shift[i] = 1'b0;
            end else begin : g_mid
                assign nxt_feed[i]  = state[i-1] ^ (fb & POLY[i]);
                assign nxt_shift[i] = state[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED;
        end else begin
            unique case (op)
                OP_SEED:  state <= SEED;
                OP_FEED:  state <= nxt_feed;
                OP_SHIFT: state <= nxt_shift;
                default:  state <= state;
            endcase
        end
    end

    assert_seed_R1: assert property (@(posedge clk) disable iff (rst)
        op == OP_SEED |=> state == SEED);

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        op == OP_HOLD |=> $stable(state));

    assert_shift_R6: assert property (@(posedge clk) disable iff (rst)
        op == OP_SHIFT |=> (state[MSB:1] == $past(state[MSB-1:0])) && !state[0]);

    // With no feedback the feed step must be a plain shift (R2)
    assert_nofb_R2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_FEED && (din == state[MSB])) |=> state[MSB:1] == $past(state[MSB-1:0]));

endmodule

// File: rtl/crc16_verdict.sv
module crc16_verdict
    import crc16_pkg::*;
#(
    parameter int           W        = 16,
    parameter logic [W-1:0] RESIDUAL = 16'h800D
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sop,
    input  logic         eod,
    input  logic [W-1:0] state,
    output logic         good,
    output logic         bad
);
    verdict_t v_q;

    always_ff @(posedge clk) begin
        if (rst || sop) begin
            v_q <= '0;
        end else if (eod) begin
            v_q.valid <= 1'b1;
            v_q.match <= (state == RESIDUAL);
        end
    end

    assign good = v_q.valid &  v_q.match;
    assign bad  = v_q.valid & ~v_q.match;

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        sop |=> !good && !bad);

    assert_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        (eod && !sop) |=> (good != bad));

    assert_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (!sop && !eod) |=> $stable({good, bad}));

endmodule

// File: rtl/crc16_serial_unit.sv
module crc16_serial_unit
    import crc16_pkg::*;
#(
    parameter int           W        = 16,
    parameter logic [W-1:0] POLY     = 16'h8005,
    parameter logic [W-1:0] SEED     = 16'hFFFF,
    parameter logic [W-1:0] RESIDUAL = 16'h800D
) (
    input  logic clk,
    input  logic rst,
    input  logic sop,
    input  logic bit_vld,
    input  logic dir_tx,
    input  logic tx_bit,
    input  logic rx_bit,
    input  logic crc_shift,
    input  logic eod,
    output logic crc_out,
    output logic good,
    output logic bad
);
    crc_op_e      op;
    logic         sel_bit;
    logic [W-1:0] state;

    assign op = decode_op(sop, bit_vld, crc_shift);

    crc16_in_mux u_mux (
        .dir_tx (dir_tx),
        .tx_bit (tx_bit),
        .rx_bit (rx_bit),
        .sel_bit(sel_bit)
    );

    crc16_lfsr #(.W(W), .POLY(POLY), .SEED(SEED)) u_lfsr (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .din  (sel_bit),
        .state(state)
    );

    crc16_verdict #(.W(W), .RESIDUAL(RESIDUAL)) u_verdict (
        .clk  (clk),
        .rst  (rst),
        .sop  (sop),
        .eod  (eod),
        .state(state),
        .good (good),
        .bad  (bad)
    );

    // Check value leaves inverted, top bit first
    assign crc_out = ~state[W-1];

    // The shifted-out bit must be the inverted former second bit (R5)
    assert_out_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |=> crc_out == !$past(state[W-2]));

endmodule

// File: tb/sim_crc16_serial_unit.sv
`timescale 1ns/1ps
module sim_crc16_serial_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sop = 1'b0, bit_vld = 1'b0, dir_tx = 1'b0;
    logic tx_bit = 1'b0, rx_bit = 1'b0, crc_shift = 1'b0, eod = 1'b0;
    logic crc_out, good, bad;

    int    n_run  = 0;
    int    n_fail = 0;
    string cur_tag = "R8";

    // Behavioural reference state
    int ref_crc   = 'hFFFF;
    bit ref_valid = 0;
    bit ref_match = 0;

    always #2 clk = ~clk;

    crc16_serial_unit u0 (
        .clk(clk), .rst(rst), .sop(sop), .bit_vld(bit_vld), .dir_tx(dir_tx),
        .tx_bit(tx_bit), .rx_bit(rx_bit), .crc_shift(crc_shift), .eod(eod),
        .crc_out(crc_out), .good(good), .bad(bad)
    );

    function automatic int poly_step(int c, bit b);
        int r;
        bit top;
        top = bit'((c >> 15) & 1);
        r = (c * 2) % 65536;
        if (b != top) r = r ^ 'h8005;
        return r;
    endfunction

    always @(posedge clk) begin
        bit in_b;
        in_b = dir_tx ? tx_bit : rx_bit;
        if (rst || sop) begin
            ref_crc = 'hFFFF;
            ref_valid = 0;
            ref_match = 0;
        end else begin
            if (eod) begin
                ref_valid = 1;
                ref_match = (ref_crc == 'h800D);
            end
            if (bit_vld && crc_shift)
                ref_crc = (ref_crc * 2) % 65536;
            else if (bit_vld)
                ref_crc = poly_step(ref_crc, in_b);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        bit exp_out;
        exp_out = !bit'((ref_crc >> 15) & 1);
        check(crc_out == exp_out, {cur_tag, " R5 crc_out"}, int'(crc_out), int'(exp_out));
        check({good, bad} == {ref_valid && ref_match, ref_valid && !ref_match},
              {cur_tag, " R7 flags"}, int'({good, bad}),
              int'({ref_valid && ref_match, ref_valid && !ref_match}));
    endtask

    task automatic cyc(input bit s, input bit v, input bit tb, input bit rb,
                       input bit d, input bit sh, input bit e);
        @(negedge clk);
        compare_all();
        sop = s; bit_vld = v; tx_bit = tb; rx_bit = rb;
        dir_tx = d; crc_shift = sh; eod = e;
    endtask

    task automatic idle();
        cyc(0, 0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0,
            1'($urandom_range(0, 1)), 0);
    endtask

    task automatic feed(input bit b, input bit tx);
        bit noise;
        noise = 1'($urandom_range(0, 1));
        cyc(0, 1, tx ? b : noise, tx ? noise : b, tx, 0, 0);
    endtask

    bit data_q[$];
    bit cap_q[$];

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int exp_word;
        int got_word;
        repeat (3) @(negedge clk);
        // Reset state: flags clear, register seeded (R8, R1)
        check(good == 0 && bad == 0, "R8 reset flags", int'({good, bad}), 0);
        check(crc_out == 0, "R1 reset seed crc_out", int'(crc_out), 0);
        rst = 1'b0;

        // Transmit pass over three bytes, LSB first (R2, R3)
        cur_tag = "R3 tx";
        cyc(1, 1, 1, 0, 1, 1, 0);   // start with other inputs active: seed wins (R1)
        for (int k = 0; k < 3; k++) begin
            int byte_v;
            byte_v = (k == 0) ? 'hA5 : ((k == 1) ? 'h3C : 'h01);
            for (int i = 0; i < 8; i++) begin
                data_q.push_back(bit'((byte_v >> i) & 1));
                feed(bit'((byte_v >> i) & 1), 1);
            end
        end
        // Shift out the check value (R5, R6)
        cur_tag = "R6 shift";
        for (int i = 0; i < 16; i++) begin
            cyc(0, 1, 0, 1'($urandom_range(0, 1)), 1, 1, 0);
            if (i == 0) exp_word = (~ref_crc) & 'hFFFF;
            cap_q.push_back(crc_out);
        end
        got_word = 0;
        foreach (cap_q[j]) got_word = got_word * 2 + int'(cap_q[j]);
        check(got_word == exp_word, "R5 check word", got_word, exp_word);
        idle(); idle();

        // Receive replay of data and check bits (R9, R3)
        cur_tag = "R9 rx good";
        cyc(1, 0, 0, 0, 0, 0, 0);
        foreach (data_q[j]) feed(data_q[j], 0);
        foreach (cap_q[j]) feed(cap_q[j], 0);
        cyc(0, 0, 1, 0, 0, 0, 1);
        idle();
        check(good == 1 && bad == 0, "R9 sound packet", int'({good, bad}), 2);
        // Flags hold across idle cycles (R8, R4)
        cur_tag = "R8 hold";
        repeat (5) idle();
        check(good == 1 && bad == 0, "R8 flags held", int'({good, bad}), 2);

        // Corrupted replay, one bit inverted (R9)
        cur_tag = "R9 rx bad";
        cyc(1, 0, 0, 0, 0, 0, 0);
        idle();
        check(good == 0 && bad == 0, "R8 sop clears", int'({good, bad}), 0);
        foreach (data_q[j]) feed((j == 9) ? !data_q[j] : data_q[j], 0);
        foreach (cap_q[j]) feed(cap_q[j], 0);
        cyc(0, 0, 0, 0, 0, 0, 1);
        idle();
        check(good == 0 && bad == 1, "R9 corrupted packet", int'({good, bad}), 1);

        // Sound replay with gaps in bit_vld (R4)
        cur_tag = "R4 gaps";
        cyc(1, 0, 0, 0, 0, 0, 0);
        foreach (data_q[j]) begin
            feed(data_q[j], 0);
            if (j % 3 == 0) idle();
        end
        foreach (cap_q[j]) begin
            idle();
            feed(cap_q[j], 0);
        end
        cyc(0, 0, 0, 0, 0, 0, 1);
        idle();
        check(good == 1 && bad == 0, "R4 gaps ignored", int'({good, bad}), 2);

        // Random packets checked against the model (R2, R7)
        cur_tag = "R2 random";
        for (int p = 0; p < 20; p++) begin
            cyc(1, 0, 0, 0, 0, 0, 0);
            for (int i = 0; i < 8 + p * 3; i++) feed(1'($urandom_range(0, 1)), 0);
            cyc(0, 0, 0, 0, 0, 0, 1);
            idle();
        end

        // Empty packet: seed compared directly, must be bad (R7)
        cur_tag = "R7 empty";
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1);
        idle();
        check(good == 0 && bad == 1, "R7 seed not residual", int'({good, bad}), 1);
        idle();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule